// File: doc/BRIEF.md
# Auto-Baud Key State Serial Responder

This block answers a host that asks for the state of ten touch keys over a single shared serial line. It has no baud rate of its own. It measures the host's request character to learn the bit period, checks that the character is the one valid request, and then sends two status bytes back at the rate it measured. The request can come in on the shared line (one-wire mode) or on a separate receive input (two-wire mode). The reply always goes out on the shared line.

The block drives the shared line push-pull only while it sends a frame. It hands the line back to the external pull-up as soon as each stop bit has been set high. An active-low change output tells the host that a key has been pressed or released since the last valid poll, so the host does not need to poll continuously.

Timing is set by the parameters `CLK_HZ`, `BAUD_MIN` and `BAUD_MAX`. For centred sampling, `CLK_HZ` should be at least 16 times `BAUD_MAX`.

Top module: `keyrep_top`

## Requirements
- R1: While reset is asserted and just after it is released, `line_oe_o` is 0 and `change_no` is 1.
- R2: The only request accepted is 0x50 sent as 8N1 (start bit 0, data LSB first, stop bit 1). Any other byte, or a 0x50 whose stop bit is sampled low, gets no reply and leaves `change_no` as it was.
- R3: The bit period in clocks is the low time from the start-bit falling edge to the first rising edge, divided by 5. A request is accepted only when that period lies in [CLK_HZ/BAUD_MAX, CLK_HZ/BAUD_MIN]. A request outside that range gets no reply.
- R4: Every reply bit lasts the measured period: the two frame starts lie 10 periods apart.
- R5: The reply's start bit begins between 1 and 3 bit periods after the end of the request's stop bit.
- R6: The reply is two 8N1 frames, sent LSB first. Frame 1 is 0x40 OR keys[5:0] (bit n = key n). Frame 2 is 0x40 OR keys[9:6] (bit n = key n+6), and its bits 4 and 5 are 0. Keys 0, 2 and 7 active give 0x45, then 0x42.
- R7: `line_oe_o` is 1 only during a reply frame. In each stop bit it is dropped after 2 clocks, with `line_o` high at the moment of release.
- R8: `change_no` goes low on any change of `keys_i` and stays low until a valid request is accepted. It is high when the reply begins if no key changed in between.
- R9: With `two_wire_i`=1 requests are taken only from `rx_i`; with `two_wire_i`=0 only from `line_i`. The reply is sent on `line_o`/`line_oe_o` in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oversampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| two_wire_i | input | 1 | 1: request arrives on rx_i; 0: request arrives on line_i |
| line_i | input | 1 | Level seen on the shared line |
| rx_i | input | 1 | Separate request input used in two-wire mode |
| keys_i | input | 10 | Debounced key states, bit n = key n |
| line_o | output | 1 | Level driven onto the shared line |
| line_oe_o | output | 1 | Drive enable for the shared line; 0 = high impedance |
| change_no | output | 1 | Active-low key-change notify (open-drain level) |

## Verification
A wrong measured period shows up in the first reply frame. The frame start spacing or the sampled data drifts within 10 bit times. A bad turnaround count moves the start bit outside the 1–3 period window at once. A validator that is too lenient answers a bad byte or an out-of-range rate within a few bit times of its stop bit. A stuck change flag is visible at `change_no` one clock after a key edge, or at the first reply start. A wrong drive enable breaks the line level seen in the stop bit.

// File: rtl/keyrep_pkg.sv
package keyrep_pkg;
  localparam int unsigned NUM_KEYS     = 10;
  localparam logic [7:0]  REQ_CHAR     = 8'h50;
  localparam int unsigned REQ_LOW_BITS = 5;   // start bit plus four leading zero data bits
  localparam logic [7:0]  REPLY_BASE   = 8'h40;
  localparam int unsigned FRAME_BITS   = 10;
  localparam int unsigned STOP_DRIVE   = 2;   // clocks the stop level is driven before release

  typedef enum logic [1:0] {RX_IDLE, RX_MEAS, RX_SAMP, RX_HOLD} rx_state_e;
  typedef enum logic [1:0] {TX_IDLE, TX_TURN, TX_BIT} tx_state_e;

  function automatic logic [7:0] reply_byte(input logic [NUM_KEYS-1:0] k, input logic sel);
    reply_byte = REPLY_BASE | (sel ? {4'b0, k[9:6]} : {2'b0, k[5:0]});
  endfunction
endpackage

// File: rtl/keyrep_sync.sv
module keyrep_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff <= '1;
    else         ff <= {ff[STAGES-2:0], d_i};
  end

  assign q_o = ff[STAGES-1];
endmodule

// File: rtl/keyrep_rx.sv
module keyrep_rx
  import keyrep_pkg::*;
#(
  parameter int unsigned CNT_W   = 12,
  parameter int unsigned PER_MIN = 33,
  parameter int unsigned PER_MAX = 160
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             line_i,
  output logic             req_o,
  output logic [CNT_W-1:0] per_o
);
  localparam int unsigned LEN_MIN = PER_MIN * REQ_LOW_BITS;
  localparam int unsigned LEN_MAX = PER_MAX * REQ_LOW_BITS;
  // expected samples after the first rising edge: remaining data bits, then stop
  localparam logic [4:0]  TAIL    = {1'b1, REQ_CHAR[7:REQ_LOW_BITS-1]};

  rx_state_e        st;
  logic             line_q;
  logic [CNT_W-1:0] cnt, per;
  logic [2:0]       idx;
  logic [CNT_W-1:0] div_w;

  assign div_w = cnt / CNT_W'(REQ_LOW_BITS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st     <= RX_IDLE;
      line_q <= 1'b1;
      cnt    <= '0;
      per    <= '0;
      idx    <= '0;
      req_o  <= 1'b0;
    end else begin
      line_q <= line_i;
      req_o  <= 1'b0;
      unique case (st)
        RX_IDLE: if (en_i && line_q && !line_i) begin
          st  <= RX_MEAS;
          cnt <= CNT_W'(1);
        end
        RX_MEAS: begin
          if (line_i) begin
            if (cnt < CNT_W'(LEN_MIN)) st <= RX_IDLE;
            else begin
              per <= div_w;
              cnt <= div_w >> 1;
              idx <= '0;
              st  <= RX_SAMP;
            end
          end else if (cnt >= CNT_W'(LEN_MAX)) st <= RX_HOLD;
          else cnt <= cnt + 1'b1;
        end
        RX_SAMP: begin
          if (cnt == '0) begin
            if (line_i != TAIL[idx]) st <= RX_HOLD;
            else if (idx == 3'd4) begin
              req_o <= 1'b1;
              st    <= RX_IDLE;
            end else begin
              idx <= idx + 1'b1;
              cnt <= per - 1'b1;
            end
          end else cnt <= cnt - 1'b1;
        end
        RX_HOLD: if (line_i) st <= RX_IDLE;
        default: st <= RX_IDLE;
      endcase
    end
  end

  assign per_o = per;

  assert_period_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (per_o >= CNT_W'(PER_MIN) && per_o <= CNT_W'(PER_MAX)));
endmodule

// File: rtl/keyrep_tx.sv
module keyrep_tx
  import keyrep_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [CNT_W-1:0]    per_i,
  input  logic [NUM_KEYS-1:0] keys_i,
  output logic                busy_o,
  output logic                line_o,
  output logic                oe_o
);
  tx_state_e           st;
  logic [CNT_W-1:0]    cnt, lim, per_q;
  logic [FRAME_BITS-1:0] sh;
  logic [3:0]          bitn;
  logic                sel;
  logic [NUM_KEYS-1:0] keys_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st     <= TX_IDLE;
      cnt    <= '0;
      lim    <= '0;
      per_q  <= '0;
      sh     <= '1;
      bitn   <= '0;
      sel    <= 1'b0;
      keys_q <= '0;
    end else begin
      unique case (st)
        TX_IDLE: if (start_i) begin
          per_q  <= per_i;
          keys_q <= keys_i;
          cnt    <= '0;
          lim    <= per_i + (per_i >> 1) - 1'b1;  // stop-sample to start bit: 1.5 periods
          st     <= TX_TURN;
        end
        TX_TURN: begin
          if (cnt == lim) begin
            sh   <= {1'b1, reply_byte(keys_q, 1'b0), 1'b0};
            cnt  <= '0;
            bitn <= '0;
            sel  <= 1'b0;
            st   <= TX_BIT;
          end else cnt <= cnt + 1'b1;
        end
        TX_BIT: begin
          if (cnt == per_q - 1'b1) begin
            cnt <= '0;
            if (bitn == 4'(FRAME_BITS-1)) begin
              if (!sel) begin
                sel  <= 1'b1;
                sh   <= {1'b1, reply_byte(keys_q, 1'b1), 1'b0};
                bitn <= '0;
              end else st <= TX_IDLE;
            end else begin
              sh   <= {1'b1, sh[FRAME_BITS-1:1]};
              bitn <= bitn + 1'b1;
            end
          end else cnt <= cnt + 1'b1;
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

  assign busy_o = (st != TX_IDLE);
  assign line_o = (st == TX_BIT) ? sh[0] : 1'b1;
  assign oe_o   = (st == TX_BIT) &&
                  ((bitn != 4'(FRAME_BITS-1)) || (cnt < CNT_W'(STOP_DRIVE)));

  assert_release_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_o) |-> $past(line_o));
  assert_start_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_o) |-> !line_o);
endmodule

// File: rtl/keyrep_chg.sv
module keyrep_chg
  import keyrep_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_KEYS-1:0] keys_i,
  input  logic                clr_i,
  output logic                chg_no
);
  logic [NUM_KEYS-1:0] keys_q;
  logic                flag;
  logic                key_diff;

  assign key_diff = (keys_i != keys_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      keys_q <= '0;
      flag   <= 1'b0;
    end else begin
      keys_q <= keys_i;
      if (key_diff)   flag <= 1'b1;  // a fresh edge outranks a poll
      else if (clr_i) flag <= 1'b0;
    end
  end

  assign chg_no = ~flag;

  assert_clear_on_poll_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !key_diff) |=> chg_no);
endmodule

// File: rtl/keyrep_top.sv
module keyrep_top
  import keyrep_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 16_000_000,
  parameter int unsigned BAUD_MIN    = 8000,
  parameter int unsigned BAUD_MAX    = 38400,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                two_wire_i,
  input  logic                line_i,
  input  logic                rx_i,
  input  logic [NUM_KEYS-1:0] keys_i,
  output logic                line_o,
  output logic                line_oe_o,
  output logic                change_no
);
  localparam int unsigned PER_MIN = CLK_HZ / BAUD_MAX;
  localparam int unsigned PER_MAX = CLK_HZ / BAUD_MIN;
  localparam int unsigned CNT_W   = $clog2(PER_MAX * REQ_LOW_BITS + 2);

  logic             line_s, rx_s, req_src;
  logic             req, tx_busy;
  logic [CNT_W-1:0] per;

  keyrep_sync #(.STAGES(SYNC_STAGES)) u_sync_line (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(line_i), .q_o(line_s));
  keyrep_sync #(.STAGES(SYNC_STAGES)) u_sync_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rx_i), .q_o(rx_s));

  assign req_src = two_wire_i ? rx_s : line_s;

  keyrep_rx #(.CNT_W(CNT_W), .PER_MIN(PER_MIN), .PER_MAX(PER_MAX)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(!tx_busy), .line_i(req_src),
    .req_o(req), .per_o(per));

  keyrep_tx #(.CNT_W(CNT_W)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(req), .per_i(per), .keys_i(keys_i),
    .busy_o(tx_busy), .line_o(line_o), .oe_o(line_oe_o));

  keyrep_chg u_chg (
    .clk_i(clk_i), .rst_ni(rst_ni), .keys_i(keys_i), .clr_i(req), .chg_no(change_no));

  assert_no_req_in_reply_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_busy |-> !req);
  assert_idle_released_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_busy |-> !line_oe_o);
endmodule

// File: tb/keyrep_top_bench.sv
module keyrep_top_bench;
  timeunit 1ns;
  timeprecision 100ps;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       two_wire = 1'b0;
  logic       host_drv = 1'b1;
  logic       rx = 1'b1;
  logic [9:0] keys = '0;
  logic       line_o, line_oe, change_n;
  logic       line_w;
  int         checks = 0;
  int         fails = 0;
  int         cyc = 0;
  logic [9:0] last_k = '0;

  assign line_w = line_oe ? line_o : host_drv;   // pull-up when host releases

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  keyrep_top #(.CLK_HZ(1_280_000)) u_keyrep_top (
    .clk_i(clk), .rst_ni(rst_n), .two_wire_i(two_wire), .line_i(line_w), .rx_i(rx),
    .keys_i(keys), .line_o(line_o), .line_oe_o(line_oe), .change_no(change_n));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input int h, input bit on_rx, input bit bad_stop);
    logic [9:0] fr;
    fr = {~bad_stop, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      if (on_rx) rx = fr[i]; else host_drv = fr[i];
      repeat (h) @(negedge clk);
    end
    rx = 1'b1;
    host_drv = 1'b1;
  endtask

  task automatic expect_none(input int h, input string req);
    bit seen;
    seen = 0;
    repeat (5 * h) begin
      @(negedge clk);
      if (line_oe) seen = 1;
    end
    check(!seen, req, seen, 0);
  endtask

  task automatic expect_reply(input int h, input logic [9:0] k);
    int d;
    int t0;
    logic [9:0] v;
    logic [7:0] exp;
    d = 0;
    while (!line_oe && d < 4 * h) begin @(negedge clk); d++; end
    check(d >= h && d <= 3 * h, "R5", d, h);
    check(change_n == 1'b1, "R8", change_n, 1);
    t0 = cyc;
    for (int s = 0; s < 2; s++) begin
      if (s == 1) begin
        d = 0;
        while (!line_oe && d < 3 * h) begin @(negedge clk); d++; end
        check((cyc - t0) >= 10 * h - 10 && (cyc - t0) <= 10 * h, "R4", cyc - t0, 10 * h);
      end
      repeat (h / 2) @(negedge clk);
      for (int b = 0; b < 10; b++) begin
        if (b > 0) repeat (h) @(negedge clk);
        v[b] = line_w;
        if (b == 9) check(!line_oe && line_w, "R7", {line_oe, line_w}, 1);
      end
      exp = (s == 0) ? (8'h40 | {2'b0, k[5:0]}) : (8'h40 | {4'b0, k[9:6]});
      check(v[8:1] == exp && !v[0], "R6", v[8:1], exp);
    end
  endtask

  task automatic poll(input int h, input logic [9:0] k, input bit tw);
    two_wire = tw;
    keys = k;
    repeat (4) @(negedge clk);
    if (k != last_k) check(change_n == 1'b0, "R8", change_n, 0);
    else             check(change_n == 1'b1, "R8", change_n, 1);
    send_byte(8'h50, h, tw, 1'b0);
    expect_reply(h, k);
    last_k = k;
    repeat (3 * h) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int per_list[9] = '{33, 34, 40, 57, 64, 88, 100, 127, 160};
    repeat (3) @(negedge clk);
    check(line_oe == 1'b0 && change_n == 1'b1, "R1", {line_oe, change_n}, 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(line_oe == 1'b0 && change_n == 1'b1, "R1", {line_oe, change_n}, 1);

    // R6 example pattern: keys 0, 2, 7
    poll(64, 10'h085, 1'b0);
    // same keys again: flag stays released (R8)
    poll(64, 10'h085, 1'b0);
    // rate sweep with varied keys (R3, R4, R5, R6)
    for (int i = 0; i < 9; i++) poll(per_list[i], 10'((i * 173 + 85) % 1024), 1'b0);
    // walking keys for bit placement (R6)
    for (int j = 0; j < 10; j++) poll(40, 10'(1 << j), 1'b0);
    poll(40, 10'h3FF, 1'b0);
    poll(40, 10'h000, 1'b0);

    // invalid requests with a pending change (R2)
    keys = 10'h2A1;
    repeat (4) @(negedge clk);
    check(change_n == 1'b0, "R8", change_n, 0);
    send_byte(8'h51, 64, 1'b0, 1'b0); expect_none(64, "R2");
    check(change_n == 1'b0, "R2", change_n, 0);
    send_byte(8'h00, 64, 1'b0, 1'b0); expect_none(64, "R2");
    check(change_n == 1'b0, "R2", change_n, 0);
    send_byte(8'h70, 64, 1'b0, 1'b0); expect_none(64, "R2");
    check(change_n == 1'b0, "R2", change_n, 0);
    send_byte(8'h50, 64, 1'b0, 1'b1); expect_none(64, "R2");
    check(change_n == 1'b0, "R2", change_n, 0);
    // rates outside the window (R3)
    send_byte(8'h50, 30, 1'b0, 1'b0); expect_none(30, "R3");
    send_byte(8'h50, 170, 1'b0, 1'b0); expect_none(170, "R3");
    check(change_n == 1'b0, "R3", change_n, 0);
    poll(64, 10'h2A1, 1'b0);

    // source selection (R9)
    two_wire = 1'b1;
    repeat (4) @(negedge clk);
    send_byte(8'h50, 57, 1'b0, 1'b0); expect_none(57, "R9");
    poll(57, 10'h1C3, 1'b1);
    poll(33, 10'h085, 1'b1);
    two_wire = 1'b0;
    repeat (4) @(negedge clk);
    send_byte(8'h50, 57, 1'b1, 1'b0); expect_none(57, "R9");
    poll(57, 10'h0F0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule